// File: doc/BRIEF.md
# GPIO Register Block with Atomic Set, Clear and Toggle Aliases

This block is a memory-mapped GPIO controller that sits on a simple single-cycle register bus. It keeps two state registers, the pin output value and the pin output enable, and drives them straight onto the pin vectors. Firmware can overwrite either register whole through its value address. It can also write to alias addresses that change only the bits written as one, forcing them high, forcing them low or, for the output value only, inverting them. Because the hardware applies the bit mask in a single clock, firmware never needs a read-modify-write sequence that could race with an interrupt handler or a second core.

Two read-only registers complete the map. One returns the pin levels after a two-flop synchronizer. The other returns a processor identifier, which comes in on a port and is captured at the moment of the read. Every access finishes in one clock. Read data is registered and appears in the cycle after the read strobe.

Top module: `gpio_alias_regs`

## Requirements
- R1: While reset is asserted and right after it, pin_out and pin_oe are all zero, so every pin is an input with a low output value, and bus_rdata is zero.
- R2: A write to word offset 0x010 replaces every bit of the output register in one clock. A read of 0x010 returns the current output register.
- R3: A write to 0x014 sets to 1 each output bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A write to 0x018 clears to 0 each output bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: A write to 0x01C inverts each output bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: The output-enable register, where 1 means output and 0 means input, is written whole at 0x020, has bits set at 0x024 and has bits cleared at 0x028. It is read back at 0x020 and drives pin_oe.
- R7: A read of 0x004 returns the pin levels that were present at the clock edge two edges before the read edge.
- R8: A read of 0x000 returns the value on chip_id at the read edge.
- R9: bus_rdata shows the selected register in the cycle after an edge where bus_re is high. It is zero after every edge where bus_re is low.
- R10: Reads of the alias offsets 0x014, 0x018, 0x01C, 0x024 and 0x028, and of any unmapped offset (including 0x02C), return zero. Writes to 0x000, 0x004 or an unmapped offset change neither register.
- R11: Address bits [1:0] are ignored, so 0x017 decodes the same as 0x014.
- R12: When a read and a write hit the same register in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data, or bit mask for the aliases |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| chip_id | input | 32 | Per-instance processor identifier |
| pin_in | input | NPIN (32) | Asynchronous pin levels |
| pin_out | output | NPIN (32) | Output value register |
| pin_oe | output | NPIN (32) | Output enable register, 1 = drive |

## Verification
The assertions check on every cycle the per-bit effect of each update: set, clear and toggle act on the masked bits and leave every other bit alone, a whole-register load replaces all bits, an idle cycle holds the state, writes to read-only or unmapped offsets change nothing, and read data is zero when there was no read or the read hit an alias. They also check that the synchronized pin value lags pin_in by exactly two edges, and that a read colliding with a write returns the old value. The address map itself can only be shown by the bench's scenarios: which offset reaches which register, the aliasing of address bits [1:0], the identifier being captured at read time, and long random mixes of accesses compared against a reference model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int DATA_W = 32;
  typedef logic [DATA_W-1:0] word_t;

  // word indices (byte offset >> 2) of the register map
  localparam int WI_ID    = 0;
  localparam int WI_PINS  = 1;
  localparam int WI_OUT   = 4;
  localparam int WI_OSET  = 5;
  localparam int WI_OCLR  = 6;
  localparam int WI_OTGL  = 7;
  localparam int WI_OE    = 8;
  localparam int WI_OESET = 9;
  localparam int WI_OECLR = 10;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_LOAD = 3'd1,
    OP_SET  = 3'd2,
    OP_CLR  = 3'd3,
    OP_TGL  = 3'd4
  } reg_op_e;

  typedef enum logic [2:0] {
    RS_ZERO = 3'd0,
    RS_ID   = 3'd1,
    RS_PINS = 3'd2,
    RS_OUT  = 3'd3,
    RS_OE   = 3'd4
  } rd_src_e;

  // next value of a state register for one bus update
  function automatic word_t apply_op(reg_op_e op, word_t cur, word_t mask);
    word_t nxt;
    case (op)
      OP_LOAD: nxt = mask;
      OP_SET:  nxt = cur | mask;
      OP_CLR:  nxt = cur & ~mask;
      OP_TGL:  nxt = cur ^ mask;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_op_e           out_op,
  output reg_op_e           oe_op,
  output rd_src_e           rsel,
  output logic              zero_read,
  output logic              ignored_write
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];   // byte lanes dropped

  function automatic logic hit(logic [WORD_W-1:0] w, int idx);
    return w == WORD_W'(idx);
  endfunction

  always_comb begin
    out_op = OP_HOLD;
    oe_op  = OP_HOLD;
    if (we) begin
      if (hit(word, WI_OUT))   out_op = OP_LOAD;
      if (hit(word, WI_OSET))  out_op = OP_SET;
      if (hit(word, WI_OCLR))  out_op = OP_CLR;
      if (hit(word, WI_OTGL))  out_op = OP_TGL;
      if (hit(word, WI_OE))    oe_op  = OP_LOAD;
      if (hit(word, WI_OESET)) oe_op  = OP_SET;
      if (hit(word, WI_OECLR)) oe_op  = OP_CLR;
    end
  end

  always_comb begin
    rsel = RS_ZERO;
    if (hit(word, WI_ID))   rsel = RS_ID;
    if (hit(word, WI_PINS)) rsel = RS_PINS;
    if (hit(word, WI_OUT))  rsel = RS_OUT;
    if (hit(word, WI_OE))   rsel = RS_OE;
  end

  assign zero_read     = (rsel == RS_ZERO);
  assign ignored_write = we && (out_op == OP_HOLD) && (oe_op == OP_HOLD);

endmodule

// File: rtl/gpio_bitreg.sv
module gpio_bitreg
  import gpio_pkg::*;
#(
  parameter int W       = 32,
  parameter bit HAS_TGL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  reg_op_e      op,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);

  reg_op_e eff_op;
  word_t   cur_w, mask_w, nxt_w;

  generate
    if (HAS_TGL) begin : g_tgl
      assign eff_op = op;
    end else begin : g_notgl
      assign eff_op = (op == OP_TGL) ? OP_HOLD : op;
    end
  endgenerate

  always_comb begin
    cur_w         = '0;
    mask_w        = '0;
    cur_w[W-1:0]  = q;
    mask_w[W-1:0] = mask;
    nxt_w         = apply_op(eff_op, cur_w, mask_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt_w[W-1:0];
  end

  // R1: state is clear on the first edge after reset release
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q == '0);
  // R2 (and R6 for the enable instance): whole-register load
  p_load_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> q == $past(mask));
  // R3 (and R6): masked bits become one
  p_set_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SET |=> (q & $past(mask)) == $past(mask));
  // R4 (and R6): masked bits become zero
  p_clr_zeros_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CLR |=> (q & $past(mask)) == '0);
  // R3/R4/R5: bits outside the mask are untouched by any alias
  p_alias_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET || op == OP_CLR || op == OP_TGL) |=>
      ((q ^ $past(q)) & ~$past(mask)) == '0);
  // R10: no update means no change
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(q));

  generate
    if (HAS_TGL) begin : g_tgl_chk
      // R5: exactly the masked bits flip
      p_tgl_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_TGL |=> (q ^ $past(q)) == $past(mask));
    end
  endgenerate

endmodule

// File: rtl/gpio_alias_regs.sv
module gpio_alias_regs
  import gpio_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       chip_id,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);

  localparam int SYNC_STAGES = 2;

  reg_op_e         out_op, oe_op;
  rd_src_e         rsel;
  logic            zero_read, ignored_write;
  logic [NPIN-1:0] pins_sync;
  logic [NPIN-1:0] wmask;
  word_t           rd_word;

  assign wmask = bus_wdata[NPIN-1:0];

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
  );

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we), .out_op(out_op), .oe_op(oe_op),
    .rsel(rsel), .zero_read(zero_read), .ignored_write(ignored_write)
  );

  gpio_bitreg #(.W(NPIN), .HAS_TGL(1'b1)) u_out (
    .clk(clk), .rst_n(rst_n), .op(out_op), .mask(wmask), .q(pin_out)
  );

  gpio_bitreg #(.W(NPIN), .HAS_TGL(1'b0)) u_oe (
    .clk(clk), .rst_n(rst_n), .op(oe_op), .mask(wmask), .q(pin_oe)
  );

  always_comb begin
    rd_word = '0;
    case (rsel)
      RS_ID:   rd_word = chip_id;
      RS_PINS: rd_word[NPIN-1:0] = pins_sync;
      RS_OUT:  rd_word[NPIN-1:0] = pin_out;
      RS_OE:   rd_word[NPIN-1:0] = pin_oe;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_word;
    else             bus_rdata <= '0;
  end

  // edges since reset, used to qualify the synchronizer check
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R9: no read strobe, no data
  p_idle_rdata_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0);
  // R10: alias and unmapped reads give zero
  p_alias_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && zero_read |=> bus_rdata == '0);
  // R10: writes with no target leave both registers alone
  p_ignored_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_write |=> $stable(pin_out) && $stable(pin_oe));
  // R12: colliding read returns the value before the write
  p_read_old_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_we && rsel == RS_OUT |=> bus_rdata[NPIN-1:0] == $past(pin_out));
  // R7: synchronized pins lag the pads by two edges (SYNC_STAGES)
  p_sync_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    warm == 2'd3 |-> pins_sync == $past(pin_in, 2));
  // R6: enable register has no toggle alias
  p_no_oe_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_op == OP_TGL |-> 1'b0 == bus_we);

endmodule

// File: tb/gpio_alias_regs_bench.sv
module gpio_alias_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] chip_id = 32'hC0DE_1234;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;

  always #2 clk = ~clk;  // 250 MHz

  gpio_alias_regs u_gpio_alias_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .chip_id(chip_id), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference
  logic [31:0] m_out = '0, m_oe = '0, m_rd = '0;
  logic [31:0] hist[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic model_edge(logic [11:0] a, logic [31:0] wd, logic we, logic re);
    logic [31:0] rv;
    int w;
    w = int'(a) / 4;
    case (w)
      0:  rv = chip_id;
      1:  rv = hist[hist.size()-2];
      4:  rv = m_out;
      8:  rv = m_oe;
      default: rv = '0;
    endcase
    if (we) begin
      case (w)
        4:  m_out = wd;
        5:  m_out = m_out | wd;
        6:  m_out = m_out & ~wd;
        7:  m_out = m_out ^ wd;
        8:  m_oe  = wd;
        9:  m_oe  = m_oe | wd;
        10: m_oe  = m_oe & ~wd;
        default: ;
      endcase
    end
    m_rd = re ? rv : 32'h0;
    hist.push_back(pin_in);
  endtask

  // one bus cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(logic [11:0] a, logic [31:0] wd, logic we, logic re);
    bus_addr = a; bus_wdata = wd; bus_we = we; bus_re = re;
    @(posedge clk);
    model_edge(a, wd, we, re);
    @(negedge clk);
    check("R2-R12 model pin_out", pin_out, m_out);
    check("R6 model pin_oe", pin_oe, m_oe);
    check("R9 model bus_rdata", bus_rdata, m_rd);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] wd); step(a, wd, 1'b1, 1'b0); endtask
  task automatic rd(logic [11:0] a);                  step(a, '0, 1'b0, 1'b1); endtask
  task automatic idle();                              step('0, '0, 1'b0, 1'b0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    pin_in = 32'h5555_AAAA;
    repeat (3) @(negedge clk);
    check("R1 reset pin_out", pin_out, 32'h0);
    check("R1 reset pin_oe", pin_oe, 32'h0);
    check("R1 reset rdata", bus_rdata, 32'h0);
    pin_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    hist.push_back('0); hist.push_back('0);
    idle();
    check("R1 after release pin_out", pin_out, 32'h0);

    // R2 direct load and read back
    wr(12'h010, 32'hA5A5_0F0F);
    rd(12'h010);
    check("R2 read output", bus_rdata, 32'hA5A5_0F0F);
    // R3 set alias
    wr(12'h014, 32'h0000_F0F0);
    check("R3 set alias", pin_out, 32'hA5A5_FFFF);
    // R11 low address bits ignored: 0x017 is the set alias
    wr(12'h017, 32'h0001_0000);
    check("R11 set via 0x017", pin_out, 32'hA5A5_FFFF);
    wr(12'h013, 32'h0000_0000);   // R11: 0x013 is the value register
    check("R11 load via 0x013", pin_out, 32'h0000_0000);
    wr(12'h010, 32'hA5A5_FFFF);
    // R4 clear alias
    wr(12'h018, 32'hFF00_000F);
    check("R4 clear alias", pin_out, 32'h00A5_FFF0);
    // R5 toggle alias
    wr(12'h01C, 32'h0F0F_0F0F);
    check("R5 toggle alias", pin_out, 32'h0FAA_F0FF);
    wr(12'h01C, 32'h0000_0000);
    check("R5 toggle zero mask", pin_out, 32'h0FAA_F0FF);

    // R6 output enable
    wr(12'h020, 32'h1234_5678);
    check("R6 oe load", pin_oe, 32'h1234_5678);
    wr(12'h024, 32'h0000_0001);
    check("R6 oe set", pin_oe, 32'h1234_5679);
    wr(12'h028, 32'h1200_0000);
    check("R6 oe clear", pin_oe, 32'h0034_5679);
    rd(12'h020);
    check("R6 oe readback", bus_rdata, 32'h0034_5679);
    wr(12'h02C, 32'hFFFF_FFFF);   // R10 no toggle alias for enables
    check("R10 0x02C write ignored", pin_oe, 32'h0034_5679);

    // R7 input synchronizer lag
    pin_in = 32'hDEAD_BEEF;
    idle();
    rd(12'h004);
    check("R7 one edge late still old", bus_rdata, 32'h0000_0000);
    rd(12'h004);
    check("R7 two edges late new", bus_rdata, 32'hDEAD_BEEF);

    // R8 identifier captured at the read
    rd(12'h000);
    check("R8 id", bus_rdata, 32'hC0DE_1234);
    chip_id = 32'h0BAD_F00D;
    rd(12'h002);
    check("R8 id changed", bus_rdata, 32'h0BAD_F00D);

    // R10 ignored writes and zero reads
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    check("R10 out unchanged", pin_out, 32'h0FAA_F0FF);
    check("R10 oe unchanged", pin_oe, 32'h0034_5679);
    foreach (hist[i]) ;
    for (int k = 0; k < 7; k++) begin
      logic [11:0] za;
      case (k)
        0: za = 12'h014; 1: za = 12'h018; 2: za = 12'h01C;
        3: za = 12'h024; 4: za = 12'h028; 5: za = 12'h02C;
        default: za = 12'h040;
      endcase
      rd(za);
      check("R10 alias/unmapped read zero", bus_rdata, 32'h0);
    end

    // R9 no read, no data
    rd(12'h010);
    idle();
    check("R9 idle rdata zero", bus_rdata, 32'h0);

    // R12 read and write together
    step(12'h010, 32'h1111_2222, 1'b1, 1'b1);
    check("R12 read returns old", bus_rdata, 32'h0FAA_F0FF);
    check("R12 write took effect", pin_out, 32'h1111_2222);

    // mixed random traffic against the model
    for (int n = 0; n < 1500; n++) begin
      logic [11:0] a;
      logic [31:0] wd;
      case ($urandom_range(0, 11))
        0: a = 12'h000; 1: a = 12'h004; 2: a = 12'h010; 3: a = 12'h014;
        4: a = 12'h018; 5: a = 12'h01C; 6: a = 12'h020; 7: a = 12'h024;
        8: a = 12'h028; 9: a = 12'h02C; 10: a = 12'h0FC;
        default: a = 12'h011;
      endcase
      wd = $urandom;
      if ($urandom_range(0, 3) == 0) pin_in = $urandom;
      step(a, wd, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule